// File: doc/BRIEF.md
# Strobed Host Register Port with Parity and Interrupt

This block is a synchronous slave port through which a host processor reads and writes a small bank of 16-bit control registers. Everything runs on the processor clock. The host pulls chip select low and keeps it low for the whole access. It marks the start of the access with an address strobe that is low for exactly one cycle, and gives the direction on a read/write select, where high means read. Each address selects one 16-bit word. Within a word the low byte sits at the lower byte address, so bus bits 7:0 carry that byte.

Each access is answered by a transfer acknowledge that is low for one cycle, two cycles after the strobe cycle. The acknowledge comes with an enable that follows chip select, so that the pad can float it while the block is not selected. Read data is driven under its own output enable. The port checks byte-wise parity on incoming write data and generates parity on read data. A control bit sets the parity sense. A level interrupt, active low, is driven from a write-one-to-clear status register gated by an enable register. The status register collects write-parity errors and external event pulses.

The access sequencer has four states. IDLE goes to CAPT when strobe and chip select are both low. In CAPT the address and direction are held. CAPT goes to ACK, and the access commits on that transition, or it drops back to IDLE if chip select rises (an abort). ACK goes to HOLD, or to IDLE if chip select rises. HOLD goes back to IDLE once chip select rises.

Top module: `mpu_reg_port`

## Requirements
- R1: After reset, ack_n and irq_n are high, both enables are low, and every register reads 0: control at word 0, status at word 1, enable at word 2, general registers at words 3 to 3+NUM_GP-1.
- R2: A strobe while chip select is high is ignored. It produces no acknowledge and changes no register.
- R3: For an accepted strobe in cycle c, ack_n is low only in cycle c+2, for exactly one cycle. ack_n is never low while chip select is high, and ack_oe is high exactly when cs_n is low.
- R4: A write stores all 16 data bits at the addressed word, and a later read of that word returns them, with the value valid on rdata in the acknowledge cycle.
- R5: A read of an unmapped address returns 0 and is still acknowledged. A write to an unmapped address changes no mapped register.
- R6: par_out[1] covers rdata[15:8] and par_out[0] covers rdata[7:0]. Each is the XOR of its byte when control bit 0 is 0 (even) and the inverted XOR when it is 1 (odd).
- R7: On a write, a par_in that differs from the parity of wdata under the current sense sets status bit 0. The write is still performed.
- R8: Status bit k+1 is set by a high evt_in[k] in a cycle. Writing 1 to a status bit clears it and writing 0 leaves it alone. A set in the same cycle as a clear leaves the bit set.
- R9: irq_n is low exactly while some status bit is set whose enable bit (word 2, same position) is 1. Clearing that bit or its enable releases irq_n.
- R10: data_oe is high only during a read, from the acknowledge cycle until chip select rises.
- R11: If chip select rises before the acknowledge cycle, the access is abandoned. No acknowledge appears and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, one cycle low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data from host |
| par_in | input | 2 | Write-data parity, bit 1 over the high byte |
| evt_in | input | NUM_EVT | Interrupt event pulses |
| rdata | output | 16 | Read data |
| par_out | output | 2 | Read-data parity, bit 1 over the high byte |
| data_oe | output | 1 | Drive enable for read data |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Drive enable for ack_n |
| irq_n | output | 1 | Interrupt, active low level |

## Verification
A wrong sequencer state shows up first at the acknowledge. It arrives a cycle early or late, it lasts two cycles, or it is missing on an aborted access. All of these are visible within three cycles of the strobe. A corrupt register, a wrong decode or a wrong parity sense shows up on the very next read of that word, through rdata and par_out in its acknowledge cycle. A wrong status or enable bit moves irq_n one cycle after the event, write or clear that should have set it.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } acc_state_e;

    localparam int unsigned ADR_CTRL  = 0;
    localparam int unsigned ADR_ISTAT = 1;
    localparam int unsigned ADR_IEN   = 2;
    localparam int unsigned ADR_GP0   = 3;
endpackage

// File: rtl/mpu_parity.sv
module mpu_parity #(
    parameter int DW = 16,
    localparam int NB = DW / 8
) (
    input  logic [DW-1:0] data,
    input  logic          odd,
    output logic [NB-1:0] par
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign par[b] = (^data[8*b +: 8]) ^ odd;
    end
endmodule

// File: rtl/mpu_port_fsm.sv
module mpu_port_fsm
    import mpu_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       as_n,
    output acc_state_e state_o,
    output logic       start_o,
    output logic       commit_o,
    output logic       ack_n_o
);
    acc_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!cs_n && !as_n) st_d = ST_CAPT;
            ST_CAPT: st_d = cs_n ? ST_IDLE : ST_ACK;
            ST_ACK:  st_d = cs_n ? ST_IDLE : ST_HOLD;
            ST_HOLD: if (cs_n) st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o  = st_q;
        start_o  = (st_q == ST_IDLE) && !cs_n && !as_n;
        commit_o = (st_q == ST_CAPT) && !cs_n;
        ack_n_o  = !((st_q == ST_ACK) && !cs_n);
    end
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
    import mpu_port_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 16,
    parameter int NUM_EVT = 3,
    parameter int NUM_GP  = 4,
    localparam int SW     = NUM_EVT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic               perr,
    input  logic [NUM_EVT-1:0] evt,
    output logic [DW-1:0]      rdata_o,
    output logic               odd_o,
    output logic [SW-1:0]      istat_o,
    output logic [SW-1:0]      ien_o,
    output logic               irq_n_o
);
    logic          odd_q;
    logic [SW-1:0] istat_q, ien_q, clr, setv;
    logic [DW-1:0] gp_q [NUM_GP];
    logic [DW-1:0] rd_mux, rdata_q;
    logic          hit_ctrl, hit_istat, hit_ien;

    assign hit_ctrl  = (int'(addr) == ADR_CTRL);
    assign hit_istat = (int'(addr) == ADR_ISTAT);
    assign hit_ien   = (int'(addr) == ADR_IEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
            ien_q <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) odd_q <= wdata[0];
            if (hit_ien)  ien_q <= wdata[SW-1:0];
        end
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                          gp_q[g] <= '0;
            else if (wr_en && (int'(addr) == ADR_GP0 + g))       gp_q[g] <= wdata;
        end
    end

    assign setv = {evt, perr};
    assign clr  = (wr_en && hit_istat) ? wdata[SW-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) istat_q <= '0;
        else        istat_q <= (istat_q & ~clr) | setv;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)  rd_mux = {{(DW-1){1'b0}}, odd_q};
        if (hit_istat) rd_mux = {{(DW-SW){1'b0}}, istat_q};
        if (hit_ien)   rd_mux = {{(DW-SW){1'b0}}, ien_q};
        for (int i = 0; i < NUM_GP; i++)
            if (int'(addr) == ADR_GP0 + i) rd_mux = gp_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign odd_o   = odd_q;
    assign istat_o = istat_q;
    assign ien_o   = ien_q;
    assign irq_n_o = ~|(istat_q & ien_q);
endmodule

// File: rtl/mpu_reg_port.sv
module mpu_reg_port
    import mpu_port_pkg::*;
#(
    parameter int NUM_EVT = 3,
    parameter int NUM_GP  = 4,
    localparam int DW     = 16,
    localparam int AW     = 16,
    localparam int NB     = DW / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               as_n,
    input  logic               rw,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [NB-1:0]      par_in,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [DW-1:0]      rdata,
    output logic [NB-1:0]      par_out,
    output logic               data_oe,
    output logic               ack_n,
    output logic               ack_oe,
    output logic               irq_n
);
    localparam int SW = NUM_EVT + 1;

    acc_state_e    st;
    logic          start, commit, rw_q, odd, perr;
    logic [AW-1:0] addr_q;
    logic [NB-1:0] par_exp;
    logic [SW-1:0] istat, ien;

    mpu_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n),
        .state_o(st), .start_o(start), .commit_o(commit), .ack_n_o(ack_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b0;
        end else if (start) begin
            addr_q <= addr;
            rw_q   <= rw;
        end
    end

    mpu_parity #(.DW(DW)) u_par_chk (.data(wdata), .odd(odd), .par(par_exp));
    assign perr = commit && !rw_q && (par_exp != par_in);

    mpu_regbank #(.DW(DW), .AW(AW), .NUM_EVT(NUM_EVT), .NUM_GP(NUM_GP)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit && !rw_q), .rd_en(commit && rw_q),
        .addr(addr_q), .wdata(wdata), .perr(perr), .evt(evt_in),
        .rdata_o(rdata), .odd_o(odd), .istat_o(istat), .ien_o(ien), .irq_n_o(irq_n)
    );

    mpu_parity #(.DW(DW)) u_par_gen (.data(rdata), .odd(odd), .par(par_out));

    assign ack_oe  = !cs_n;
    assign data_oe = rw_q && !cs_n && ((st == ST_ACK) || (st == ST_HOLD));
endmodule

// File: rtl/mpu_reg_port_chk.sv
module mpu_reg_port_chk
    import mpu_port_pkg::*;
#(
    parameter int NUM_EVT = 3,
    localparam int SW     = NUM_EVT + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               as_n,
    input logic               ack_n,
    input logic               data_oe,
    input logic               irq_n,
    input acc_state_e         st,
    input logic               commit,
    input logic               rw_q,
    input logic [15:0]        addr_q,
    input logic [15:0]        wdata,
    input logic [1:0]         par_in,
    input logic               odd,
    input logic [SW-1:0]      istat,
    input logic [SW-1:0]      ien,
    input logic [NUM_EVT-1:0] evt_in
);
    logic wr_istat, wr_ien, bad_par;
    assign wr_istat = commit && !rw_q && (int'(addr_q) == ADR_ISTAT);
    assign wr_ien   = commit && !rw_q && (int'(addr_q) == ADR_IEN);
    assign bad_par  = par_in != {(^wdata[15:8]) ^ odd, (^wdata[7:0]) ^ odd};

    p_no_ack_unselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ack_n);
    p_ack_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !cs_n);
    p_ack_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |=> ack_n);
    p_ack_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && !as_n && !cs_n) ##1 !cs_n |=> !ack_n);
    p_perr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rw_q && bad_par) |=> istat[0]);
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (istat[0] && !wr_istat) |=> istat[0]);
    p_evt_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|({evt_in, 1'b0} & ien)) && !wr_ien) |=> !irq_n);
    p_dataoe_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !cs_n);
endmodule

bind mpu_reg_port mpu_reg_port_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ack_n(ack_n),
    .data_oe(data_oe), .irq_n(irq_n), .st(st), .commit(commit), .rw_q(rw_q),
    .addr_q(addr_q), .wdata(wdata), .par_in(par_in), .odd(odd),
    .istat(istat), .ien(ien), .evt_in(evt_in)
);

// File: tb/mpu_reg_port_tb.sv
module mpu_reg_port_tb_top;
    localparam int NUM_EVT = 3;
    localparam int NUM_GP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, as_n = 1'b1, rw = 1'b1;
    logic [15:0] addr = '0, wdata = '0;
    logic [1:0]  par_in = '0;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic [15:0] rdata;
    logic [1:0]  par_out;
    logic        data_oe, ack_n, ack_oe, irq_n;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mpu_reg_port #(.NUM_EVT(NUM_EVT), .NUM_GP(NUM_GP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .rw(rw),
        .addr(addr), .wdata(wdata), .par_in(par_in), .evt_in(evt_in),
        .rdata(rdata), .par_out(par_out), .data_oe(data_oe),
        .ack_n(ack_n), .ack_oe(ack_oe), .irq_n(irq_n)
    );

    function automatic logic [1:0] xpar(input logic [15:0] d, input logic o);
        return {(^d[15:8]) ^ o, (^d[7:0]) ^ o};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [15:0] r_d;
    logic [1:0]  r_p;
    logic        r_ack, r_oe;
    logic        cur_odd = 1'b0;

    // Called at a falling edge; strobe is in the following clock cycle.
    task automatic acc(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic badp, input logic [NUM_EVT-1:0] ev);
        logic a0, a1, a2;
        cs_n = 0; as_n = 0; rw = !wr; addr = a; wdata = d;
        par_in = badp ? ~xpar(d, cur_odd) : xpar(d, cur_odd);
        @(negedge clk); as_n = 1; a0 = ack_n; evt_in = ev;
        @(negedge clk); a1 = ack_n; r_d = rdata; r_p = par_out; r_oe = data_oe; evt_in = '0;
        @(negedge clk); a2 = ack_n; cs_n = 1;
        @(negedge clk);
        r_ack = a0 && !a1 && a2;
    endtask

    task automatic wr16(input logic [15:0] a, input logic [15:0] d);
        acc(1'b1, a, d, 1'b0, '0);
        chk("R3 write ack timing", 16'(r_ack), 16'd1);
    endtask

    task automatic rd16(input logic [15:0] a, input logic [15:0] exp, input string req);
        acc(1'b0, a, 16'h0, 1'b0, '0);
        chk(req, r_d, exp);
        chk("R3 read ack timing", 16'(r_ack), 16'd1);
        chk("R6 read parity", 16'(r_p), 16'(xpar(exp, cur_odd)));
        chk("R10 data_oe in read ack", 16'(r_oe), 16'd1);
    endtask

    logic [15:0] gp_model [NUM_GP];

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack_n idle", 16'(ack_n), 16'd1);
        chk("R1 irq_n idle", 16'(irq_n), 16'd1);
        chk("R1 ack_oe low", 16'(ack_oe), 16'd0);
        chk("R1 data_oe low", 16'(data_oe), 16'd0);
        for (int a = 0; a < 3 + NUM_GP; a++) rd16(16'(a), 16'h0, "R1 reset value");

        // R4 R6 sweep over both senses, every general register, several patterns
        for (int o = 0; o < 2; o++) begin
            wr16(16'h0000, 16'(o));
            cur_odd = o[0];
            rd16(16'h0000, 16'(o), "R6 sense bit readback");
            for (int g = 0; g < NUM_GP; g++) begin
                for (int p = 0; p < 5; p++) begin
                    logic [15:0] v;
                    case (p)
                        0: v = 16'h0000;
                        1: v = 16'hFFFF;
                        2: v = 16'h00FF ^ 16'(o * 16'hFFFF);
                        3: v = 16'(16'h0001 << (g * 4 + p));
                        default: v = 16'(g * 16'h1357 + o * 16'h0F0F + 16'h2468);
                    endcase
                    wr16(16'(3 + g), v);
                    gp_model[g] = v;
                    rd16(16'(3 + g), v, "R4 readback");
                    // data_oe must be low after a write's ack
                    chk("R10 data_oe idle", 16'(data_oe), 16'd0);
                end
            end
            rd16(16'h0001, 16'h0, "R7 no error on good parity");
        end

        // R5 unmapped addresses
        for (int a = 3 + NUM_GP; a < 24; a++) begin
            wr16(16'(a), 16'hDEAD);
            rd16(16'(a), 16'h0, "R5 unmapped reads zero");
        end
        wr16(16'hFFFF, 16'hBEEF);
        rd16(16'hFFFF, 16'h0, "R5 unmapped top reads zero");
        for (int g = 0; g < NUM_GP; g++) rd16(16'(3 + g), gp_model[g], "R5 mapped unchanged");

        // R2 strobe with chip select high
        cs_n = 1; as_n = 0; rw = 0; addr = 16'h0003; wdata = 16'h5A5A;
        @(negedge clk); as_n = 1;
        for (int k = 0; k < 4; k++) begin
            chk("R2 no ack unselected", 16'(ack_n), 16'd1);
            @(negedge clk);
        end
        rd16(16'h0003, gp_model[0], "R2 no write unselected");

        // R11 abort before ack
        cs_n = 0; as_n = 0; rw = 0; addr = 16'h0003; wdata = 16'h1111;
        par_in = xpar(16'h1111, cur_odd);
        @(negedge clk); as_n = 1; cs_n = 1;
        for (int k = 0; k < 3; k++) begin
            chk("R11 no ack on abort", 16'(ack_n), 16'd1);
            @(negedge clk);
        end
        rd16(16'h0003, gp_model[0], "R11 no write on abort");

        // R7 parity error: write still lands, status bit 0 set
        acc(1'b1, 16'h0004, 16'h1234, 1'b1, '0);
        chk("R3 bad-parity write acked", 16'(r_ack), 16'd1);
        rd16(16'h0004, 16'h1234, "R7 write kept");
        rd16(16'h0001, 16'h0001, "R7 error flagged");
        chk("R9 masked irq high", 16'(irq_n), 16'd1);
        wr16(16'h0002, 16'h0001);
        chk("R9 enabled irq low", 16'(irq_n), 16'd0);
        wr16(16'h0002, 16'h0000);
        chk("R9 mask releases", 16'(irq_n), 16'd1);
        wr16(16'h0002, 16'h0001);
        chk("R9 re-enable low", 16'(irq_n), 16'd0);
        wr16(16'h0001, 16'h0001);
        chk("R8 w1c releases irq", 16'(irq_n), 16'd1);
        rd16(16'h0001, 16'h0000, "R8 cleared");

        // R8 events set their bits; R9 masking per bit
        for (int k = 0; k < NUM_EVT; k++) begin
            @(negedge clk); evt_in = NUM_EVT'(1 << k);
            @(negedge clk); evt_in = '0;
            chk("R9 event masked", 16'(irq_n), 16'd1);
        end
        rd16(16'h0001, 16'(((1 << NUM_EVT) - 1) << 1), "R8 event bits");
        wr16(16'h0001, 16'h0000);
        rd16(16'h0001, 16'(((1 << NUM_EVT) - 1) << 1), "R8 write zero keeps");
        wr16(16'h0002, 16'hFFFF);
        for (int k = 0; k < NUM_EVT; k++) begin
            chk("R9 pending irq low", 16'(irq_n), 16'd0);
            wr16(16'h0001, 16'(2 << k));
        end
        chk("R9 all cleared irq high", 16'(irq_n), 16'd1);

        // R8 set wins over clear in the same cycle
        @(negedge clk); evt_in = 1; @(negedge clk); evt_in = '0;
        acc(1'b1, 16'h0001, 16'h0002, 1'b0, NUM_EVT'(1));
        rd16(16'h0001, 16'h0002, "R8 event beats clear");
        acc(1'b1, 16'h0001, 16'h0003, 1'b1, '0);
        rd16(16'h0001, 16'h0001, "R8 parity error beats clear");
        wr16(16'h0001, 16'h0001);
        chk("R9 final release", 16'(irq_n), 16'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule